// File: doc/BRIEF.md
# Asynchronous Serial Receive Framer with Line-Break Handling

This block turns an asynchronous serial line into characters. It runs on the system clock and acts only in cycles where a sample-enable pulse arrives, at sixteen pulses per bit cell. It finds the start of a character on the first low sample and confirms it half a bit later. It then takes 5 to 8 data bits, least significant first, an optional parity bit and the stop bit, each sampled once near the middle of its cell. Every character leaves the block as a single-cycle strobe that carries the data and three status flags: parity error, framing error and line break.

Two line conditions get special handling. A low stop bit does not send the framer back to hunting for a falling edge. The framer treats that low cell as the start bit of the next character, checks it once more on the following sample, and goes straight to the data bits. A line held low for longer than one whole character produces one all-zero character marked as a break. After that, nothing is accepted until the line has been high for half a bit. Word length, parity mode and stop-bit count are static inputs. They must not change while a character is in flight. The serial input is expected to be already synchronous to the clock.

Top module: `uart_rx_framer`

## Requirements
- R1: `char_valid_o` is high for exactly one clock, only in the cycle after a sample-enable cycle, and data and all flags read zero whenever it is low.
- R2: A low sample while idle starts a candidate start bit. The eighth following sample is checked again, and if the line is high there the candidate is dropped without output.
- R3: Data bits are sampled every sixteen samples after start confirmation and shifted in LSB first. `wlen_i` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, and unused upper data bits read zero.
- R4: `par_mode_i` 2'b01 is odd parity and 2'b10 is even parity. Both add one parity bit after the data. 2'b00 and 2'b11 add no parity bit. The parity-error flag is set when the received parity bit disagrees with the parity computed over the data bits, and it is always zero when parity is off.
- R5: The stop bit is sampled sixteen samples after the last data or parity sample. If it is high, the character is output from that sample with the framing flag clear.
- R6: If the stop sample is low and the character is not all zeros (data and any parity bit), the character is output at once with the framing flag set. If the next sample is also low, data capture restarts at once and the first data bit is sampled sixteen samples after the bad stop sample.
- R7: If the sample after a low stop bit is high, the framer returns to idle and outputs nothing more from that cell.
- R8: If the stop sample is low and the character is all zeros, output is held back. If the line then rises before a break is seen, a zero character with the framing flag set (parity flag as computed) is output on the first high sample.
- R9: The character time is C = 16 × (1 + data bits + parity bit + stop bits), where `stop2_i` = 1 selects two stop bits. When the sample taken C samples after the first low one is still low, exactly one character is output: data zero, break and framing flags set, parity flag clear.
- R10: After a break, low samples are ignored until eight high samples in a row have been seen. A start bit on the very next sample after that is accepted.
- R11: After reset the strobe is low and the framer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Serial line, idles high, already synchronous |
| tick_i | input | 1 | Sample enable, 16 pulses per bit cell |
| wlen_i | input | 2 | Data bit count minus five |
| par_mode_i | input | 2 | 00 none, 01 odd, 10 even, 11 none |
| stop2_i | input | 1 | 1 selects two stop bits for break timing |
| char_valid_o | output | 1 | One-cycle character strobe |
| char_data_o | output | 8 | Received data, right aligned |
| char_pe_o | output | 1 | Parity error flag |
| char_fe_o | output | 1 | Framing error flag |
| char_bi_o | output | 1 | Break flag |

## Verification
Two decisions can fall on the same sample. One is the early rise that ends an all-zero framing-error character. The other is the break threshold. Both are settled on the sample exactly C after the first low one. The bench holds an all-zero frame low for exactly C samples in one case and C+1 in another, and expects a plain framing-error character in the first case and a break in the second, in the same cycle. The bench also sends a bad stop bit that doubles as the next start bit, so that one sample both reports a framing error and starts the next character. The two characters are then checked for timing and content against a sample-level model of the line.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_RESYNC,
        RX_BRKCHK,
        RX_BRKHOLD
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              pe;
        logic              fe;
        logic              bi;
    } rx_char_t;

    function automatic logic [3:0] word_bits(input logic [1:0] wl);
        return 4'd5 + {2'b00, wl};
    endfunction

    function automatic logic parity_on(input logic [1:0] pm);
        return (pm == 2'b01) || (pm == 2'b10);
    endfunction

    // value the parity bit should carry given the xor of the data bits
    function automatic logic parity_expect(input logic [1:0] pm, input logic ones);
        return (pm == 2'b01) ? ~ones : ones;
    endfunction

    function automatic int unsigned frame_bits(input logic [1:0] wl,
                                               input logic [1:0] pm,
                                               input logic       two_stop);
        return 32'd1 + 32'(word_bits(wl)) + 32'(parity_on(pm)) + (two_stop ? 32'd2 : 32'd1);
    endfunction

endpackage

// File: rtl/uart_rx_runlen.sv
module uart_rx_runlen #(
    parameter int OSR   = 16,
    parameter int RUN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             rxd_i,
    output logic [RUN_W-1:0] low_run_o,
    output logic             half_high_o
);
    localparam int HALF = OSR / 2;
    localparam int HW   = $clog2(HALF + 1);
    localparam logic [RUN_W-1:0] LOW_MAX  = '1;
    localparam logic [HW-1:0]    HIGH_SAT = HW'(HALF);
    localparam logic [HW-1:0]    HIGH_TRG = HW'(HALF - 1);

    logic [RUN_W-1:0] low_q;
    logic [HW-1:0]    high_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q  <= '0;
            high_q <= '0;
        end else if (tick_i) begin
            if (rxd_i) begin
                low_q <= '0;
                if (high_q != HIGH_SAT) high_q <= high_q + 1'b1;
            end else begin
                high_q <= '0;
                if (low_q != LOW_MAX) low_q <= low_q + 1'b1;
            end
        end
    end

    assign low_run_o   = low_q;
    assign half_high_o = tick_i && rxd_i && (high_q == HIGH_TRG);

endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser #(
    parameter int DATA_W = 8,
    parameter int NB_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              shift_i,
    input  logic              bit_i,
    input  logic [NB_W-1:0]   nbits_i,
    output logic [DATA_W-1:0] data_o,
    output logic              ones_o
);
    logic [DATA_W-1:0] sh_q;
    logic [NB_W-1:0]   shamt;

    always_ff @(posedge clk) begin
        if (rst || clear_i) sh_q <= '0;
        else if (shift_i)   sh_q <= {bit_i, sh_q[DATA_W-1:1]};
    end

    assign shamt  = NB_W'(DATA_W) - nbits_i;
    assign data_o = sh_q >> shamt;
    assign ones_o = ^data_o;

endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rxd_i,
    input  logic              tick_i,
    input  logic [1:0]        wlen_i,
    input  logic [1:0]        par_mode_i,
    input  logic              stop2_i,
    output logic              char_valid_o,
    output logic [DATA_W-1:0] char_data_o,
    output logic              char_pe_o,
    output logic              char_fe_o,
    output logic              char_bi_o
);
    localparam int CNT_W = $clog2(OSR);
    localparam int RUN_W = $clog2(12 * OSR + 2);
    localparam int NB_W  = 4;
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

    rx_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [NB_W-1:0]  bit_idx_q;
    logic             par_q;
    rx_char_t         out_q;
    logic             valid_q;

    logic [NB_W-1:0]   nbits;
    logic              par_en;
    logic [RUN_W-1:0]  char_ticks;
    logic [RUN_W-1:0]  low_run;
    logic              half_high;
    logic              sample_pt;
    logic [DATA_W-1:0] rx_data;
    logic              rx_ones;
    logic              frame_zero;
    logic              pe_now;
    logic              shift_en;
    logic              clear_en;

    assign nbits      = word_bits(wlen_i);
    assign par_en     = parity_on(par_mode_i);
    assign char_ticks = RUN_W'(frame_bits(wlen_i, par_mode_i, stop2_i) * OSR);
    assign sample_pt  = tick_i && (cnt_q == LAST);
    assign frame_zero = (rx_data == '0) && (!par_en || !par_q);
    assign pe_now     = par_en && (par_q != parity_expect(par_mode_i, rx_ones));
    assign shift_en   = sample_pt && (state_q == RX_DATA);
    assign clear_en   = tick_i && !rxd_i &&
                        (((state_q == RX_START) && (cnt_q == MID)) || (state_q == RX_RESYNC));

    uart_rx_runlen #(.OSR(OSR), .RUN_W(RUN_W)) runlen_i (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_i),
        .rxd_i       (rxd_i),
        .low_run_o   (low_run),
        .half_high_o (half_high)
    );

    uart_rx_deser #(.DATA_W(DATA_W), .NB_W(NB_W)) deser_i (
        .clk     (clk),
        .rst     (rst),
        .clear_i (clear_en),
        .shift_i (shift_en),
        .bit_i   (rxd_i),
        .nbits_i (nbits),
        .data_o  (rx_data),
        .ones_o  (rx_ones)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= RX_IDLE;
            cnt_q     <= '0;
            bit_idx_q <= '0;
            par_q     <= 1'b0;
            out_q     <= '0;
            valid_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            out_q   <= '0;
            if (tick_i) begin
                case (state_q)
                    RX_IDLE: begin
                        if (!rxd_i) begin
                            state_q <= RX_START;
                            cnt_q   <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt_q == MID) begin
                            cnt_q     <= '0;
                            bit_idx_q <= '0;
                            state_q   <= rxd_i ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt_q == LAST) begin
                            cnt_q     <= '0;
                            bit_idx_q <= bit_idx_q + 1'b1;
                            if (bit_idx_q == nbits - 1'b1)
                                state_q <= par_en ? RX_PAR : RX_STOP;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        if (cnt_q == LAST) begin
                            cnt_q   <= '0;
                            par_q   <= rxd_i;
                            state_q <= RX_STOP;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt_q == LAST) begin
                            cnt_q <= '0;
                            if (rxd_i) begin
                                valid_q <= 1'b1;
                                out_q   <= '{data: rx_data, pe: pe_now, fe: 1'b0, bi: 1'b0};
                                state_q <= RX_IDLE;
                            end else if (frame_zero) begin
                                state_q <= RX_BRKCHK;
                            end else begin
                                valid_q <= 1'b1;
                                out_q   <= '{data: rx_data, pe: pe_now, fe: 1'b1, bi: 1'b0};
                                state_q <= RX_RESYNC;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_RESYNC: begin
                        if (!rxd_i) begin
                            state_q   <= RX_DATA;
                            cnt_q     <= CNT_W'(1);
                            bit_idx_q <= '0;
                        end else begin
                            state_q <= RX_IDLE;
                        end
                    end
                    RX_BRKCHK: begin
                        if (rxd_i) begin
                            valid_q <= 1'b1;
                            out_q   <= '{data: '0, pe: pe_now, fe: 1'b1, bi: 1'b0};
                            state_q <= RX_IDLE;
                        end else if (low_run >= char_ticks) begin
                            valid_q <= 1'b1;
                            out_q   <= '{data: '0, pe: 1'b0, fe: 1'b1, bi: 1'b1};
                            state_q <= RX_BRKHOLD;
                        end
                    end
                    RX_BRKHOLD: begin
                        if (half_high) state_q <= RX_IDLE;
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end

    assign char_valid_o = valid_q;
    assign char_data_o  = out_q.data;
    assign char_pe_o    = out_q.pe;
    assign char_fe_o    = out_q.fe;
    assign char_bi_o    = out_q.bi;

endmodule

// File: rtl/uart_rx_framer_chk.sv
module uart_rx_framer_chk
    import uart_rx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rxd_i,
    input logic              tick_i,
    input logic [1:0]        wlen_i,
    input logic [1:0]        par_mode_i,
    input logic              stop2_i,
    input logic              char_valid_o,
    input logic [DATA_W-1:0] char_data_o,
    input logic              char_pe_o,
    input logic              char_fe_o,
    input logic              char_bi_o
);
    // R1
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        char_valid_o |=> !char_valid_o);

    // R1
    strobe_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        char_valid_o |-> $past(tick_i));

    // R1
    quiet_fields_chk: assert property (@(posedge clk) disable iff (rst)
        !char_valid_o |-> (char_data_o == '0 && !char_pe_o && !char_fe_o && !char_bi_o));

    // R3
    word_width_chk: assert property (@(posedge clk) disable iff (rst)
        char_valid_o |-> ((char_data_o >> word_bits(wlen_i)) == '0));

    // R4
    no_parity_chk: assert property (@(posedge clk) disable iff (rst)
        (char_valid_o && !parity_on(par_mode_i)) |-> !char_pe_o);

    // R9
    break_char_chk: assert property (@(posedge clk) disable iff (rst)
        (char_valid_o && char_bi_o) |-> (char_data_o == '0 && char_fe_o && !char_pe_o));

endmodule

bind uart_rx_framer uart_rx_framer_chk chk_i (.*);

// File: tb/uart_rx_framer_tb.sv
module uart_rx_framer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] wlen = 2'd3;
    logic [1:0] pm = 2'd0;
    logic       stop2 = 1'b0;
    logic       v_o;
    logic [7:0] d_o;
    logic       pe_o, fe_o, bi_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_rx_framer dut_i (
        .clk          (clk),
        .rst          (rst),
        .rxd_i        (rxd),
        .tick_i       (tick),
        .wlen_i       (wlen),
        .par_mode_i   (pm),
        .stop2_i      (stop2),
        .char_valid_o (v_o),
        .char_data_o  (d_o),
        .char_pe_o    (pe_o),
        .char_fe_o    (fe_o),
        .char_bi_o    (bi_o)
    );

    typedef struct {
        int         t;
        logic [7:0] d;
        logic       pe;
        logic       fe;
        logic       bi;
        string      req;
    } exp_t;

    int    checks = 0;
    int    errors = 0;
    int    tk = 0;
    bit    done = 1'b0;
    bit    line_q[$];
    exp_t  exp_q[$];
    string quiet_req = "R11";

    task automatic check(input bit ok, input string req, input logic [11:0] act, input logic [11:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s tick=%0d actual=%h expected=%h", req, tk, act, expv);
        end
    endtask

    function automatic bit pon();
        return (pm == 2'd1) || (pm == 2'd2);
    endfunction

    task automatic push_level(input bit v, input int n);
        for (int i = 0; i < n; i++) line_q.push_back(v);
    endtask

    task automatic add_exp(input int t, input logic [7:0] d, input bit pe, input bit fe, input bit bi, input string req);
        exp_t e;
        e.t = t; e.d = d; e.pe = pe; e.fe = fe; e.bi = bi; e.req = req;
        exp_q.push_back(e);
    endtask

    // builds one character on the line; a stop cell count of zero leaves the stop cell to the caller
    task automatic push_frame(input logic [7:0] d, input bit flip, input bit stop_v, input int stop_cells, input string req);
        int         s = tk + line_q.size();
        int         n = 5 + int'(wlen);
        int         p = pon() ? 1 : 0;
        logic [7:0] m = d & 8'((1 << n) - 1);
        bit         pb;
        push_level(1'b0, 16);
        for (int i = 0; i < n; i++) push_level(m[i], 16);
        if (pon()) begin
            pb = ^m;
            if (pm == 2'd1) pb = ~pb;
            if (flip) pb = ~pb;
            push_level(pb, 16);
        end
        push_level(stop_v, 16 * stop_cells);
        add_exp(s + 8 + 16 * (n + p + 1), m, flip && pon(), ~stop_v, 1'b0, req);
    endtask

    task automatic run_line();
        logic [11:0] act;
        exp_t        e;
        while (line_q.size() > 0) begin
            rxd  = line_q.pop_front();
            tick = 1'b1;
            @(posedge clk);
            @(negedge clk);
            tick = 1'b0;
            act = {v_o, d_o, pe_o, fe_o, bi_o};
            if (exp_q.size() > 0 && exp_q[0].t == tk) begin
                e = exp_q.pop_front();
                check(act == {1'b1, e.d, e.pe, e.fe, e.bi}, e.req, act, {1'b1, e.d, e.pe, e.fe, e.bi});
            end else begin
                check(act == 12'h000, quiet_req, act, 12'h000);
            end
            @(posedge clk);
            @(negedge clk);
            act = {v_o, d_o, pe_o, fe_o, bi_o};
            check(act == 12'h000, "R1", act, 12'h000);
            tk++;
        end
        while (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            check(1'b0, e.req, 12'h000, {1'b1, e.d, e.pe, e.fe, e.bi});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int s;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check({v_o, d_o, pe_o, fe_o, bi_o} == 12'h000, "R11", {v_o, d_o, pe_o, fe_o, bi_o}, 12'h000);
        push_level(1'b1, 20);
        run_line();

        // R3 R5: 8 data bits, no parity, back to back
        quiet_req = "R5";
        wlen = 2'd3; pm = 2'd0; stop2 = 1'b0;
        push_frame(8'hA5, 1'b0, 1'b1, 1, "R3");
        push_frame(8'h3C, 1'b0, 1'b1, 1, "R5");
        push_level(1'b1, 20);
        run_line();

        // R4: 5 bits odd parity, good then corrupted
        quiet_req = "R4";
        wlen = 2'd0; pm = 2'd1;
        push_frame(8'h1B, 1'b0, 1'b1, 1, "R4");
        push_frame(8'h1B, 1'b1, 1'b1, 1, "R4");
        push_level(1'b1, 20);
        run_line();

        // R3 R4: 6 bits even parity, two stop bits
        wlen = 2'd1; pm = 2'd2; stop2 = 1'b1;
        push_frame(8'h2A, 1'b0, 1'b1, 2, "R3");
        push_frame(8'h2A, 1'b1, 1'b1, 2, "R4");
        push_level(1'b1, 20);
        run_line();

        // R3: 7 bits no parity, upper bit of input discarded
        wlen = 2'd2; pm = 2'd0; stop2 = 1'b0;
        push_frame(8'hFF, 1'b0, 1'b1, 1, "R3");
        push_level(1'b1, 20);
        run_line();

        // R4: mode 11 carries no parity bit
        wlen = 2'd3; pm = 2'd3;
        push_frame(8'h81, 1'b0, 1'b1, 1, "R4");
        push_level(1'b1, 20);
        run_line();

        // R2: eight low samples then high is rejected
        quiet_req = "R2";
        pm = 2'd0;
        push_level(1'b0, 8);
        push_level(1'b1, 30);
        push_frame(8'hC3, 1'b0, 1'b1, 1, "R2");
        push_level(1'b1, 20);
        run_line();

        // R6: bad stop bit becomes the next start bit
        quiet_req = "R6";
        push_frame(8'h55, 1'b0, 1'b0, 0, "R6");
        push_frame(8'h96, 1'b0, 1'b1, 1, "R6");
        push_level(1'b1, 20);
        run_line();

        // R7: bad stop bit that rises on the next sample
        quiet_req = "R7";
        push_frame(8'h12, 1'b0, 1'b0, 0, "R7");
        push_level(1'b0, 9);
        push_level(1'b1, 60);
        run_line();

        // R8: all-zero 7E1 frame, line rises exactly at the character time
        quiet_req = "R8";
        wlen = 2'd2; pm = 2'd2;
        s = tk + line_q.size();
        push_level(1'b0, 160);
        push_level(1'b1, 30);
        add_exp(s + 160, 8'h00, 1'b0, 1'b1, 1'b0, "R8");
        run_line();

        // R8 R9 boundary with 8N1: C = 160
        wlen = 2'd3; pm = 2'd0;
        s = tk + line_q.size();
        push_level(1'b0, 160);
        push_level(1'b1, 30);
        add_exp(s + 160, 8'h00, 1'b0, 1'b1, 1'b0, "R8");
        run_line();
        quiet_req = "R9";
        s = tk + line_q.size();
        push_level(1'b0, 161);
        push_level(1'b1, 30);
        add_exp(s + 160, 8'h00, 1'b0, 1'b1, 1'b1, "R9");
        run_line();

        // R9 R10: long break, short high, ignored low, then exactly half a bit high
        quiet_req = "R10";
        s = tk + line_q.size();
        push_level(1'b0, 300);
        add_exp(s + 160, 8'h00, 1'b0, 1'b1, 1'b1, "R9");
        push_level(1'b1, 7);
        push_level(1'b0, 16);
        push_level(1'b1, 8);
        push_frame(8'h5A, 1'b0, 1'b1, 1, "R10");
        push_level(1'b1, 20);
        run_line();

        // R9: 7E2, C = 176
        wlen = 2'd2; pm = 2'd2; stop2 = 1'b1;
        s = tk + line_q.size();
        push_level(1'b0, 200);
        add_exp(s + 176, 8'h00, 1'b0, 1'b1, 1'b1, "R9");
        push_level(1'b1, 20);
        push_frame(8'h33, 1'b0, 1'b1, 2, "R10");
        push_level(1'b1, 20);
        run_line();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule